// File: doc/BRIEF.md
# NAND Page Hamming ECC Generator and Checker

This block computes a 24-bit Hamming-style parity code over one 512-byte NAND page while the page streams in one byte per clock. The code is built from twelve bit-pairs: three pairs of column parity over the bit position inside each byte, and nine pairs of row parity over the 9-bit byte address. Every one of the 24 bits carries computed parity; none is padded. The finished code is presented on a one-cycle strobe and is meant to be stored as three bytes at the start of the page's spare area: `code_o[7:0]` first, then `code_o[15:8]`, then `code_o[23:16]`.

On a read, the page is streamed through the same generator. A stored code is then presented together with a compare request. The block XORs it with the most recently generated code and classifies the result. The possible outcomes are a clean page, a correctable single-bit data error with the byte address and bit index to flip, an error confined to the stored code itself, or an uncorrectable pattern. Driving the NAND bus and rewriting the corrected byte are left to the surrounding logic.

Top module: `nand_ecc_gen`

## Requirements
- R1: After `rst_ni` is released and before any input, `code_valid_o` and `chk_valid_o` are 0 and `code_o` is all zeros.
- R2: For pair k in 0..2, `code_o[2k]` is the XOR of every data bit whose bit index has bit k clear, and `code_o[2k+1]` is the XOR of every data bit whose bit index has bit k set. The XOR runs over all 512 bytes of the page.
- R3: For pair j in 0..8, `code_o[6+2j]` is the XOR of the parities of all bytes whose page address has bit j clear, and `code_o[7+2j]` is the XOR of the parities of all bytes whose address has bit j set. The first byte of the page has address 0.
- R4: `code_valid_o` is high for exactly one cycle, in the cycle that follows the clock edge at which the 512th byte is accepted, and `code_o` holds that code until the next page completes.
- R5: A byte with `byte_sop_i` high restarts the page at address 0 and drops any partial page. Cycles with `byte_valid_i` low do not advance the address. Valid bytes that arrive while no page is open (no start-of-page seen since the last completed page) have no effect.
- R6: A `cmp_req_i` pulse compares `cmp_code_i` with the current `code_o`. `chk_valid_o` is high for one cycle on the next cycle. `chk_status_o` encodes 0 = match, 1 = correctable data bit, 2 = error in the stored code only, 3 = uncorrectable.
- R7: When every one of the twelve pairs of the XOR differs in exactly one bit, the status is 1. `chk_byte_o` bit j is XOR bit 7+2j, and `chk_bit_o` bit k is XOR bit 2k+1. These name the flipped data bit. For any other status both fields are 0.
- R8: When the XOR has exactly one bit set, the status is 2.
- R9: Any other non-zero XOR pattern gives status 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| byte_valid_i | input | 1 | Data byte present this cycle |
| byte_sop_i | input | 1 | Byte is the first of a page |
| byte_data_i | input | 8 | Page data byte |
| code_valid_o | output | 1 | One-cycle strobe: a page code is ready |
| code_o | output | 24 | Last generated page code |
| cmp_req_i | input | 1 | Compare request |
| cmp_code_i | input | 24 | Stored code to compare against |
| chk_valid_o | output | 1 | Compare result strobe |
| chk_status_o | output | 2 | Compare result class |
| chk_byte_o | output | 9 | Address of the byte to correct |
| chk_bit_o | output | 3 | Bit index to correct |

## Verification
A wrong address counter or a stale accumulator shows at the ports as a wrong row-parity pair. It also shows as a `code_valid_o` strobe that arrives one byte early or late, and both appear in the cycle that follows the 512th byte. A dropped restart on start-of-page leaves parity from the abandoned partial page in the next code. Column-pair faults only show when the page contains bits of the affected index. Decoder faults appear one cycle after the compare request, as a wrong class or a misplaced correction address. For that reason, single flips at the first and last byte and at both ends of the bit range are exercised.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
  typedef enum logic [1:0] {
    CHK_CLEAN    = 2'd0,
    CHK_DATA_FIX = 2'd1,
    CHK_CODE_FIX = 2'd2,
    CHK_FATAL    = 2'd3
  } chk_status_e;
endpackage

// File: rtl/nand_ecc_col_par.sv
// Column-parity contribution of one byte: pair k splits bits on index bit k.
module nand_ecc_col_par #(
  parameter int DATA_W = 8,
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]  data_i,
  output logic [2*BIT_W-1:0] par_o
);
  for (genvar k = 0; k < BIT_W; k++) begin : g_pair
    always_comb begin
      par_o[2*k]   = 1'b0;
      par_o[2*k+1] = 1'b0;
      for (int i = 0; i < DATA_W; i++) begin
        if (((i >> k) & 1) != 0) par_o[2*k+1] = par_o[2*k+1] ^ data_i[i];
        else                     par_o[2*k]   = par_o[2*k]   ^ data_i[i];
      end
    end
  end
endmodule

// File: rtl/nand_ecc_row_par.sv
// Row-parity contribution of one byte: byte parity steered by each address bit.
module nand_ecc_row_par #(
  parameter int ADDR_W = 9
) (
  input  logic              byte_par_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [2*ADDR_W-1:0] par_o
);
  for (genvar j = 0; j < ADDR_W; j++) begin : g_pair
    assign par_o[2*j]   = byte_par_i & ~addr_i[j];
    assign par_o[2*j+1] = byte_par_i &  addr_i[j];
  end
endmodule

// File: rtl/nand_ecc_cmp_dec.sv
module nand_ecc_cmp_dec
  import nand_ecc_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int BIT_W  = 3,
  localparam int PAIRS  = ADDR_W + BIT_W,
  localparam int CODE_W = 2 * PAIRS
) (
  input  logic [CODE_W-1:0] syn_i,
  output chk_status_e       status_o,
  output logic [ADDR_W-1:0] byte_o,
  output logic [BIT_W-1:0]  bit_o
);
  logic [PAIRS-1:0] pair_split;
  logic [PAIRS-1:0] pair_hi;

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    assign pair_split[p] = syn_i[2*p] ^ syn_i[2*p+1];
    assign pair_hi[p]    = syn_i[2*p+1];
  end

  always_comb begin
    status_o = CHK_FATAL;
    byte_o   = '0;
    bit_o    = '0;
    if (syn_i == '0) begin
      status_o = CHK_CLEAN;
    end else if (&pair_split) begin
      status_o = CHK_DATA_FIX;
      bit_o    = pair_hi[BIT_W-1:0];
      byte_o   = pair_hi[PAIRS-1:BIT_W];
    end else if ($onehot(syn_i)) begin
      status_o = CHK_CODE_FIX;
    end
  end
endmodule

// File: rtl/nand_ecc_gen.sv
module nand_ecc_gen
  import nand_ecc_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8,
  localparam int BIT_W  = $clog2(DATA_W),
  localparam int COL_W  = 2 * BIT_W,
  localparam int CODE_W = 2 * (ADDR_W + BIT_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_valid_i,
  input  logic              byte_sop_i,
  input  logic [DATA_W-1:0] byte_data_i,
  output logic              code_valid_o,
  output logic [CODE_W-1:0] code_o,
  input  logic              cmp_req_i,
  input  logic [CODE_W-1:0] cmp_code_i,
  output logic              chk_valid_o,
  output logic [1:0]        chk_status_o,
  output logic [ADDR_W-1:0] chk_byte_o,
  output logic [BIT_W-1:0]  chk_bit_o
);
  logic              active_q;
  logic [ADDR_W-1:0] cnt_q;
  logic [CODE_W-1:0] acc_q, code_q;
  logic              code_valid_q;

  logic              accept, last_byte;
  logic [ADDR_W-1:0] byte_addr;
  logic [COL_W-1:0]  col_par;
  logic [CODE_W-COL_W-1:0] row_par;
  logic [CODE_W-1:0] acc_next;

  assign accept    = byte_valid_i & (byte_sop_i | active_q);
  assign byte_addr = byte_sop_i ? '0 : cnt_q;
  assign last_byte = accept & (&byte_addr);

  nand_ecc_col_par #(.DATA_W(DATA_W)) u_col (
    .data_i (byte_data_i),
    .par_o  (col_par)
  );

  nand_ecc_row_par #(.ADDR_W(ADDR_W)) u_row (
    .byte_par_i (^byte_data_i),
    .addr_i     (byte_addr),
    .par_o      (row_par)
  );

  // A start-of-page byte discards the running accumulator
  assign acc_next = (byte_sop_i ? '0 : acc_q) ^ {row_par, col_par};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q     <= 1'b0;
      cnt_q        <= '0;
      acc_q        <= '0;
      code_q       <= '0;
      code_valid_q <= 1'b0;
    end else begin
      code_valid_q <= last_byte;
      if (accept) begin
        cnt_q    <= byte_addr + 1'b1;
        active_q <= ~last_byte;
        acc_q    <= last_byte ? '0 : acc_next;
        if (last_byte) code_q <= acc_next;
      end
    end
  end

  assign code_valid_o = code_valid_q;
  assign code_o       = code_q;

  chk_status_e       dec_status;
  logic [ADDR_W-1:0] dec_byte;
  logic [BIT_W-1:0]  dec_bit;

  nand_ecc_cmp_dec #(.ADDR_W(ADDR_W), .BIT_W(BIT_W)) u_dec (
    .syn_i    (cmp_code_i ^ code_q),
    .status_o (dec_status),
    .byte_o   (dec_byte),
    .bit_o    (dec_bit)
  );

  logic              chk_valid_q;
  chk_status_e       chk_status_q;
  logic [ADDR_W-1:0] chk_byte_q;
  logic [BIT_W-1:0]  chk_bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_valid_q  <= 1'b0;
      chk_status_q <= CHK_CLEAN;
      chk_byte_q   <= '0;
      chk_bit_q    <= '0;
    end else begin
      chk_valid_q <= cmp_req_i;
      if (cmp_req_i) begin
        chk_status_q <= dec_status;
        chk_byte_q   <= dec_byte;
        chk_bit_q    <= dec_bit;
      end
    end
  end

  assign chk_valid_o  = chk_valid_q;
  assign chk_status_o = chk_status_q;
  assign chk_byte_o   = chk_byte_q;
  assign chk_bit_o    = chk_bit_q;
endmodule

// File: rtl/nand_ecc_gen_chk.sv
module nand_ecc_gen_chk #(
  parameter int ADDR_W = 9,
  parameter int BIT_W  = 3,
  localparam int CODE_W = 2 * (ADDR_W + BIT_W)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              code_valid_o,
  input logic [CODE_W-1:0] code_o,
  input logic              cmp_req_i,
  input logic [CODE_W-1:0] cmp_code_i,
  input logic              chk_valid_o,
  input logic [1:0]        chk_status_o,
  input logic [ADDR_W-1:0] chk_byte_o,
  input logic [BIT_W-1:0]  chk_bit_o
);
  p_code_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_valid_o |=> !code_valid_o);

  p_code_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !code_valid_o |-> $stable(code_o));

  p_chk_latency_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_req_i |=> chk_valid_o);

  p_chk_only_req_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmp_req_i |=> !chk_valid_o);

  p_clean_match_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_req_i ##1 (chk_status_o == 2'd0) |-> $past(cmp_code_i) == $past(code_o));

  p_fix_weight_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_req_i ##1 (chk_status_o == 2'd1) |->
      $countones($past(cmp_code_i) ^ $past(code_o)) == ADDR_W + BIT_W);

  p_fix_fields_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_valid_o && chk_status_o != 2'd1 |-> chk_byte_o == '0 && chk_bit_o == '0);

  p_code_err_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_req_i ##1 (chk_status_o == 2'd2) |->
      $countones($past(cmp_code_i) ^ $past(code_o)) == 1);

  p_fatal_nonzero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_req_i ##1 (chk_status_o == 2'd3) |->
      $countones($past(cmp_code_i) ^ $past(code_o)) > 1);
endmodule

bind nand_ecc_gen nand_ecc_gen_chk #(.ADDR_W(ADDR_W), .BIT_W(BIT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .code_valid_o (code_valid_o),
  .code_o       (code_o),
  .cmp_req_i    (cmp_req_i),
  .cmp_code_i   (cmp_code_i),
  .chk_valid_o  (chk_valid_o),
  .chk_status_o (chk_status_o),
  .chk_byte_o   (chk_byte_o),
  .chk_bit_o    (chk_bit_o)
);

// File: tb/nand_ecc_gen_tb.sv
module nand_ecc_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NBYTES = 512;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        byte_valid = 1'b0, byte_sop = 1'b0;
  logic [7:0]  byte_data = '0;
  logic        code_valid;
  logic [23:0] code;
  logic        cmp_req = 1'b0;
  logic [23:0] cmp_code = '0;
  logic        chk_valid;
  logic [1:0]  chk_status;
  logic [8:0]  chk_byte;
  logic [2:0]  chk_bit;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0]  pg [NBYTES];
  logic [23:0] exp_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_ecc_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .byte_valid_i(byte_valid), .byte_sop_i(byte_sop), .byte_data_i(byte_data),
    .code_valid_o(code_valid), .code_o(code),
    .cmp_req_i(cmp_req), .cmp_code_i(cmp_code),
    .chk_valid_o(chk_valid), .chk_status_o(chk_status),
    .chk_byte_o(chk_byte), .chk_bit_o(chk_bit)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Reference code: every set data bit toggles one half of each pair
  function automatic logic [23:0] model_code();
    logic [23:0] c = '0;
    for (int a = 0; a < NBYTES; a++)
      for (int i = 0; i < 8; i++)
        if (pg[a][i]) begin
          for (int k = 0; k < 3; k++) c[2*k + ((i >> k) & 1)] ^= 1'b1;
          for (int j = 0; j < 9; j++) c[6 + 2*j + ((a >> j) & 1)] ^= 1'b1;
        end
    return c;
  endfunction

  task automatic fill(input int kind, input int seed);
    logic [15:0] lfsr = 16'hACE1 ^ seed[15:0];
    for (int a = 0; a < NBYTES; a++) begin
      case (kind)
        0: pg[a] = 8'h00;
        1: pg[a] = 8'hFF;
        2: pg[a] = a[7:0];
        default: begin
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          pg[a] = lfsr[7:0] ^ lfsr[15:8];
        end
      endcase
    end
  endtask

  // Driver: pushes expected code, streams page, checks strobe timing (R4)
  task automatic send_page(input bit gaps);
    exp_q.push_back(model_code());
    for (int a = 0; a < NBYTES; a++) begin
      if (gaps && (a % 7 == 3)) begin
        @(negedge clk); byte_valid = 1'b0; byte_sop = 1'b0;
      end
      @(negedge clk);
      byte_valid = 1'b1; byte_sop = (a == 0); byte_data = pg[a];
      if (a == NBYTES - 1) check("R4 no early strobe", code_valid, 1'b0);
    end
    @(negedge clk);
    byte_valid = 1'b0; byte_sop = 1'b0;
    check("R4 strobe after 512th byte", code_valid, 1'b1);
    @(negedge clk);
    check("R4 strobe one cycle", code_valid, 1'b0);
  endtask

  task automatic do_cmp(input string tag, input logic [23:0] stored,
                        input logic [1:0] st, input logic [8:0] b, input logic [2:0] bi);
    @(negedge clk); cmp_req = 1'b1; cmp_code = stored;
    @(negedge clk); cmp_req = 1'b0;
    check({tag, " R6 valid"}, chk_valid, 1'b1);
    check({tag, " status"}, chk_status, st);
    check({tag, " byte"}, chk_byte, b);
    check({tag, " bit"}, chk_bit, bi);
    @(negedge clk);
    check({tag, " R6 valid drops"}, chk_valid, 1'b0);
  endtask

  // Monitor: scoreboard pop on each strobe (R2, R3)
  always @(negedge clk) begin
    if (rst_n && code_valid) begin
      if (exp_q.size() == 0) check("R5 unexpected code strobe", 1, 0);
      else check("R2/R3 page code", code, exp_q.pop_front());
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [23:0] clean;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check("R1 code_valid reset", code_valid, 1'b0);
    check("R1 chk_valid reset", chk_valid, 1'b0);
    check("R1 code reset", code, 24'h0);

    // R2/R3: several patterns
    fill(0, 0); send_page(0);
    check("R2 zero page code", code, 24'h0);
    fill(1, 0); send_page(0);
    fill(2, 0); send_page(1);
    fill(3, 5); send_page(0);
    // single set bit at last byte, bit 7: all upper halves set
    fill(0, 0); pg[511] = 8'h80; send_page(0);
    check("R3 single bit code", code, 24'hAAAAAA);
    fill(0, 0); pg[0] = 8'h01; send_page(0);
    check("R2 single bit low code", code, 24'h555555);

    // R5: partial page abandoned by restart
    fill(3, 9);
    for (int a = 0; a < 100; a++) begin
      @(negedge clk); byte_valid = 1'b1; byte_sop = (a == 0); byte_data = 8'h5A ^ a[7:0];
    end
    send_page(0);
    // R5: stray bytes with no open page are ignored
    for (int a = 0; a < 600; a++) begin
      @(negedge clk); byte_valid = 1'b1; byte_sop = 1'b0; byte_data = a[7:0];
    end
    @(negedge clk); byte_valid = 1'b0;
    check("R5 stray bytes no strobe", exp_q.size(), 0);
    check("R5 stray bytes code kept", code, model_code());

    // R6..R9 compare
    fill(3, 21); clean = model_code(); send_page(0);
    do_cmp("R6 match", clean, 2'd0, 9'd0, 3'd0);
    pg[0][0] = ~pg[0][0]; send_page(0);
    do_cmp("R7 fix byte0 bit0", clean, 2'd1, 9'd0, 3'd0);
    pg[0][0] = ~pg[0][0];
    pg[511][7] = ~pg[511][7]; send_page(0);
    do_cmp("R7 fix byte511 bit7", clean, 2'd1, 9'd511, 3'd7);
    pg[511][7] = ~pg[511][7];
    pg[300][5] = ~pg[300][5]; send_page(1);
    do_cmp("R7 fix byte300 bit5", clean, 2'd1, 9'd300, 3'd5);
    pg[300][5] = ~pg[300][5];
    send_page(0);
    do_cmp("R8 code bit 0", clean ^ 24'h000001, 2'd2, 9'd0, 3'd0);
    do_cmp("R8 code bit 23", clean ^ 24'h800000, 2'd2, 9'd0, 3'd0);
    pg[10][1] = ~pg[10][1]; pg[200][6] = ~pg[200][6]; send_page(0);
    do_cmp("R9 two data bits", clean, 2'd3, 9'd0, 3'd0);
    do_cmp("R9 two code bits", code ^ 24'h000101, 2'd3, 9'd0, 3'd0);

    repeat (3) @(negedge clk);
    check("R4 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule